// File: doc/BRIEF.md
# GPIO Control Register with Shared-Pin Multiplexer

This block is a single memory-mapped control register that drives three bidirectional general-purpose pins and two output-only pins. For each bidirectional pin, software picks the direction and the value to drive. A read always returns the level actually present at each bidirectional pin. That level is taken through a synchroniser, so the read is free of metastability.

A 3-bit routing field in the same register decides what appears on two shared pins: a data pin and a clock pin. One setting gives both pins to an internal serial-EEPROM engine, and in that setting the data pin is bidirectional. The other valid settings place the two output-only values, the transmit-enable and receive-valid status, or the transmit and receive clocks onto the shared pins. The two remaining codes are reserved and leave both shared pins undriven.

Each pin is presented as three separate signals: an output value, an output enable, and a sampled input. The pad ring builds the physical tri-state buffer from these.

Top module: `gpio_pinmux`

## Requirements
- R1: After reset, every direction bit is 0 (all three bidirectional pins are inputs, `gpio_oe` = 000), both output-only values are 0, the routing field is 000, and `rd_data` is 0 while all pin inputs are low.
- R2: Bits 10:8 of a write set the direction of pins 2..0 (1 = output). `gpio_oe` shows the new value from the clock edge that takes the write.
- R3: Bits 2:0 of a write are the drive values of pins 2..0. `gpio_o[i]` carries the written bit while `gpio_oe[i]` is 1 and is 0 while the pin is an input.
- R4: `rd_data[2:0]` returns the level on `gpio_i` through a two-stage synchroniser. A change sampled at one rising edge is visible after the second rising edge and not after the first.
- R5: Bits 4:3 of a write drive `gpo_o[1:0]` (bit 3 to `gpo_o[0]`, bit 4 to `gpo_o[1]`) and read back in the same positions.
- R6: Only bits 22:20, 10:8, 4:3 and 2:0 of `rd_data` can be nonzero. Writes to every other bit have no effect on any output.
- R7: Routing code 000 (bits 22:20) gives the shared data pin to the EEPROM engine: `shr_dat_o`=`eng_dat_out`, `shr_dat_oe`=`eng_dat_oe`, `shr_clk_o`=`eng_clk`, `shr_clk_oe`=1, and `eng_dat_in` follows `shr_dat_i`.
- R8: For routing codes 001..101, both shared output enables are 1. Data/clock sources are: 001 = `gpo_o[0]` / `gpo_o[1]`; 010 = `gpo_o[0]` / `mac_rx_dv`; 011 = `mac_tx_en` / `gpo_o[1]`; 100 = `mac_tx_en` / `mac_rx_dv`; 101 = `mac_tx_clk` / `mac_rx_clk`.
- R9: Routing codes 110 and 111 drive both shared output enables and both shared output values to 0.
- R10: Under any routing code other than 000, `eng_dat_in` is 0, whatever the level of `shr_dat_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| gpio_i | input | 3 | Sampled level of the bidirectional pins |
| gpio_o | output | 3 | Drive value of the bidirectional pins |
| gpio_oe | output | 3 | Output enable of the bidirectional pins |
| gpo_o | output | 2 | Output-only pin values |
| eng_dat_out | input | 1 | EEPROM engine data to drive |
| eng_dat_oe | input | 1 | EEPROM engine data output enable |
| eng_clk | input | 1 | EEPROM engine serial clock |
| eng_dat_in | output | 1 | Shared data pin level returned to the EEPROM engine |
| mac_tx_en | input | 1 | Transmit-enable status |
| mac_rx_dv | input | 1 | Receive-valid status |
| mac_tx_clk | input | 1 | Transmit clock |
| mac_rx_clk | input | 1 | Receive clock |
| shr_dat_i | input | 1 | Sampled level of the shared data pin |
| shr_dat_o | output | 1 | Shared data pin drive value |
| shr_dat_oe | output | 1 | Shared data pin output enable |
| shr_clk_o | output | 1 | Shared clock pin drive value |
| shr_clk_oe | output | 1 | Shared clock pin output enable |

## Verification
The hardest case to reach is a read that shows a pin level different from the value written. That happens only when a pin is an input and the external level differs from the stored drive bit, or when a level changed only one edge earlier. The bench models each pad as its own output while enabled and as a separate random external level otherwise. Random writes therefore often leave the stored data bit and the read level disagreeing. A directed step then changes the external level and samples after one edge and after two, which pins the synchroniser depth exactly.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;

    localparam int REG_W    = 32;
    localparam int N_GPIO   = 3;
    localparam int N_GPO    = 2;
    localparam int SEL_W    = 3;
    localparam int SYNC_LEN = 2;

    localparam int DAT_LSB  = 0;
    localparam int GPO_LSB  = 3;
    localparam int DIR_LSB  = 8;
    localparam int SEL_LSB  = 20;

    typedef enum logic [SEL_W-1:0] {
        ROUTE_EEPROM   = 3'd0,
        ROUTE_GPO_GPO  = 3'd1,
        ROUTE_GPO_RXDV = 3'd2,
        ROUTE_TXEN_GPO = 3'd3,
        ROUTE_TXEN_RXDV= 3'd4,
        ROUTE_CLOCKS   = 3'd5,
        ROUTE_RSV_A    = 3'd6,
        ROUTE_RSV_B    = 3'd7
    } route_e;

    typedef struct packed {
        logic [N_GPIO-1:0] dir;
        logic [N_GPIO-1:0] dat;
        logic [N_GPO-1:0]  gpo;
        route_e            route;
    } ctrl_t;

    typedef struct packed {
        logic dat_o;
        logic dat_oe;
        logic clk_o;
        logic clk_oe;
    } shared_t;

    function automatic ctrl_t decode_write(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.dir   = w[DIR_LSB +: N_GPIO];
        c.dat   = w[DAT_LSB +: N_GPIO];
        c.gpo   = w[GPO_LSB +: N_GPO];
        c.route = route_e'(w[SEL_LSB +: SEL_W]);
        return c;
    endfunction

    function automatic logic [REG_W-1:0] encode_read(input ctrl_t c,
                                                     input logic [N_GPIO-1:0] lvl);
        logic [REG_W-1:0] r;
        r = '0;
        r[DIR_LSB +: N_GPIO] = c.dir;
        r[DAT_LSB +: N_GPIO] = lvl;
        r[GPO_LSB +: N_GPO]  = c.gpo;
        r[SEL_LSB +: SEL_W]  = c.route;
        return r;
    endfunction

    function automatic logic [REG_W-1:0] live_mask();
        logic [REG_W-1:0] m;
        m = '0;
        m[DIR_LSB +: N_GPIO] = '1;
        m[DAT_LSB +: N_GPIO] = '1;
        m[GPO_LSB +: N_GPO]  = '1;
        m[SEL_LSB +: SEL_W]  = '1;
        return m;
    endfunction

endpackage

// File: rtl/gpio_pinmux_regs.sv
module gpio_pinmux_regs
    import gpio_pinmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_t            ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '{dir: '0, dat: '0, gpo: '0, route: ROUTE_EEPROM};
        end else if (wr_en) begin
            ctrl <= decode_write(wr_data);
        end
    end

endmodule

// File: rtl/gpio_pinmux_sync.sv
module gpio_pinmux_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_pinmux_route.sv
module gpio_pinmux_route
    import gpio_pinmux_pkg::*;
(
    input  route_e           route,
    input  logic [N_GPO-1:0] gpo,
    input  logic             eng_dat_out,
    input  logic             eng_dat_oe,
    input  logic             eng_clk,
    input  logic             mac_tx_en,
    input  logic             mac_rx_dv,
    input  logic             mac_tx_clk,
    input  logic             mac_rx_clk,
    input  logic             shr_dat_i,
    output shared_t          pins,
    output logic             eng_dat_in
);

    always_comb begin
        pins = '0;
        unique case (route)
            ROUTE_EEPROM:    pins = '{dat_o: eng_dat_out, dat_oe: eng_dat_oe,
                                      clk_o: eng_clk,     clk_oe: 1'b1};
            ROUTE_GPO_GPO:   pins = '{dat_o: gpo[0],     dat_oe: 1'b1,
                                      clk_o: gpo[1],     clk_oe: 1'b1};
            ROUTE_GPO_RXDV:  pins = '{dat_o: gpo[0],     dat_oe: 1'b1,
                                      clk_o: mac_rx_dv,  clk_oe: 1'b1};
            ROUTE_TXEN_GPO:  pins = '{dat_o: mac_tx_en,  dat_oe: 1'b1,
                                      clk_o: gpo[1],     clk_oe: 1'b1};
            ROUTE_TXEN_RXDV: pins = '{dat_o: mac_tx_en,  dat_oe: 1'b1,
                                      clk_o: mac_rx_dv,  clk_oe: 1'b1};
            ROUTE_CLOCKS:    pins = '{dat_o: mac_tx_clk, dat_oe: 1'b1,
                                      clk_o: mac_rx_clk, clk_oe: 1'b1};
            default:         pins = '0;
        endcase
    end

    assign eng_dat_in = (route == ROUTE_EEPROM) ? shr_dat_i : 1'b0;

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pinmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [N_GPIO-1:0] gpio_i,
    output logic [N_GPIO-1:0] gpio_o,
    output logic [N_GPIO-1:0] gpio_oe,
    output logic [N_GPO-1:0]  gpo_o,
    input  logic              eng_dat_out,
    input  logic              eng_dat_oe,
    input  logic              eng_clk,
    output logic              eng_dat_in,
    input  logic              mac_tx_en,
    input  logic              mac_rx_dv,
    input  logic              mac_tx_clk,
    input  logic              mac_rx_clk,
    input  logic              shr_dat_i,
    output logic              shr_dat_o,
    output logic              shr_dat_oe,
    output logic              shr_clk_o,
    output logic              shr_clk_oe
);

    ctrl_t             ctrl;
    shared_t           pins;
    logic [N_GPIO-1:0] pin_lvl;

    gpio_pinmux_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    gpio_pinmux_sync #(.WIDTH(N_GPIO), .STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (gpio_i),
        .q   (pin_lvl)
    );

    gpio_pinmux_route u_route (
        .route       (ctrl.route),
        .gpo         (ctrl.gpo),
        .eng_dat_out (eng_dat_out),
        .eng_dat_oe  (eng_dat_oe),
        .eng_clk     (eng_clk),
        .mac_tx_en   (mac_tx_en),
        .mac_rx_dv   (mac_rx_dv),
        .mac_tx_clk  (mac_tx_clk),
        .mac_rx_clk  (mac_rx_clk),
        .shr_dat_i   (shr_dat_i),
        .pins        (pins),
        .eng_dat_in  (eng_dat_in)
    );

    assign gpio_oe    = ctrl.dir;
    assign gpio_o     = ctrl.dat & ctrl.dir;
    assign gpo_o      = ctrl.gpo;
    assign rd_data    = encode_read(ctrl, pin_lvl);
    assign shr_dat_o  = pins.dat_o;
    assign shr_dat_oe = pins.dat_oe;
    assign shr_clk_o  = pins.clk_o;
    assign shr_clk_oe = pins.clk_oe;

endmodule

// File: rtl/gpio_pinmux_chk.sv
module gpio_pinmux_chk
    import gpio_pinmux_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic [N_GPIO-1:0] gpio_i,
    input logic [N_GPIO-1:0] gpio_o,
    input logic [N_GPIO-1:0] gpio_oe,
    input logic [N_GPO-1:0]  gpo_o,
    input logic              shr_dat_oe,
    input logic              shr_clk_oe
);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2
    dir_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> gpio_oe == $past(wr_data[DIR_LSB +: N_GPIO]));

    // R5
    gpo_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> gpo_o == $past(wr_data[GPO_LSB +: N_GPO]));

    // R3
    input_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (gpio_o & ~gpio_oe) == '0);

    // R4
    sync_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> rd_data[DAT_LSB +: N_GPIO] == $past(gpio_i, 2));

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~live_mask()) == '0);

    // R9
    reserved_route_float_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[SEL_LSB +: SEL_W] >= 3'd6) |-> (!shr_dat_oe && !shr_clk_oe));

endmodule

bind gpio_pinmux gpio_pinmux_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .gpio_i     (gpio_i),
    .gpio_o     (gpio_o),
    .gpio_oe    (gpio_oe),
    .gpo_o      (gpo_o),
    .shr_dat_oe (shr_dat_oe),
    .shr_clk_oe (shr_clk_oe)
);

// File: tb/gpio_pinmux_test.sv
module gpio_pinmux_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  gpio_i, gpio_o, gpio_oe;
    logic [1:0]  gpo_o;
    logic        eng_dat_out = 0, eng_dat_oe = 0, eng_clk = 0, eng_dat_in;
    logic        mac_tx_en = 0, mac_rx_dv = 0, mac_tx_clk = 0, mac_rx_clk = 0;
    logic        shr_dat_i = 0, shr_dat_o, shr_dat_oe, shr_clk_o, shr_clk_oe;
    logic [2:0]  ext_lvl = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    assign gpio_i = (gpio_oe & gpio_o) | (~gpio_oe & ext_lvl);

    gpio_pinmux uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .gpio_i(gpio_i), .gpio_o(gpio_o), .gpio_oe(gpio_oe), .gpo_o(gpo_o),
        .eng_dat_out(eng_dat_out), .eng_dat_oe(eng_dat_oe), .eng_clk(eng_clk),
        .eng_dat_in(eng_dat_in), .mac_tx_en(mac_tx_en), .mac_rx_dv(mac_rx_dv),
        .mac_tx_clk(mac_tx_clk), .mac_rx_clk(mac_rx_clk), .shr_dat_i(shr_dat_i),
        .shr_dat_o(shr_dat_o), .shr_dat_oe(shr_dat_oe),
        .shr_clk_o(shr_clk_o), .shr_clk_oe(shr_clk_oe)
    );

    localparam logic [31:0] LIVE = 32'h0070_071F;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = $urandom;
    endtask

    // expected shared pins {dat_o, dat_oe, clk_o, clk_oe} from the routing table
    function automatic logic [3:0] exp_shared(input logic [2:0] sel, input logic [1:0] g);
        case (sel)
            3'd0: return {eng_dat_out, eng_dat_oe, eng_clk, 1'b1};
            3'd1: return {g[0], 1'b1, g[1], 1'b1};
            3'd2: return {g[0], 1'b1, mac_rx_dv, 1'b1};
            3'd3: return {mac_tx_en, 1'b1, g[1], 1'b1};
            3'd4: return {mac_tx_en, 1'b1, mac_rx_dv, 1'b1};
            3'd5: return {mac_tx_clk, 1'b1, mac_rx_clk, 1'b1};
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [2:0] exp_pad(input logic [31:0] w, input logic [2:0] ext);
        return (w[10:8] & w[2:0]) | (~w[10:8] & ext);
    endfunction

    task automatic check_all(input logic [31:0] w);
        logic [3:0] sh;
        sh = exp_shared(w[22:20], w[4:3]);
        check("R2 dir", {29'd0, gpio_oe}, {29'd0, w[10:8]});
        check("R3 drive", {29'd0, gpio_o}, {29'd0, w[10:8] & w[2:0]});
        check("R5 gpo", {30'd0, gpo_o}, {30'd0, w[4:3]});
        check("R4/R6 read", rd_data, (w & LIVE & ~32'h7) | {29'd0, exp_pad(w, ext_lvl)});
        check(w[22:20] >= 3'd6 ? "R9 shared" : (w[22:20] == 3'd0 ? "R7 shared" : "R8 shared"),
              {28'd0, shr_dat_o, shr_dat_oe, shr_clk_o, shr_clk_oe}, {28'd0, sh});
        check(w[22:20] == 3'd0 ? "R7 eng_in" : "R10 eng_in",
              {31'd0, eng_dat_in}, {31'd0, (w[22:20] == 3'd0) ? shr_dat_i : 1'b0});
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'h1A2B_3C4D));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 rd_data", rd_data, 32'd0);
        check("R1 gpio_oe", {29'd0, gpio_oe}, 32'd0);
        check("R1 gpo_o", {30'd0, gpo_o}, 32'd0);
        check("R1 clk_oe", {31'd0, shr_clk_oe}, 32'd1);

        // R6 and R9: all ones, reserved bits ignored, reserved route floats
        reg_write(32'hFFFF_FFFF);
        check("R6 reserved", rd_data & ~LIVE, 32'd0);
        check("R9 dat_oe", {31'd0, shr_dat_oe}, 32'd0);
        check("R9 clk_oe", {31'd0, shr_clk_oe}, 32'd0);
        check("R2 all out", {29'd0, gpio_oe}, 32'd7);

        // R4 synchroniser depth: inputs, step the external level
        reg_write(32'h0000_0000);
        ext_lvl = 3'b000;
        @(negedge clk); @(negedge clk); @(negedge clk);
        ext_lvl = 3'b101;
        @(negedge clk);
        check("R4 one edge", {29'd0, rd_data[2:0]}, 32'd0);
        @(negedge clk);
        check("R4 two edges", {29'd0, rd_data[2:0]}, 32'd5);

        // R3: input pin with data bit set stays low on gpio_o, read shows external level
        reg_write(32'h0000_0207);
        ext_lvl = 3'b000;
        @(negedge clk); @(negedge clk);
        check("R3 masked drive", {29'd0, gpio_o}, 32'd2);
        check("R3 read level", {29'd0, rd_data[2:0]}, 32'd2);

        // R10 and R7: shared data input return path
        shr_dat_i = 1'b1;
        reg_write(32'h0010_0000);
        check("R10 eng_in gated", {31'd0, eng_dat_in}, 32'd0);
        reg_write(32'h0000_0000);
        check("R7 eng_in pass", {31'd0, eng_dat_in}, 32'd1);

        // directed sweep of every routing code
        for (int s = 0; s < 8; s++) begin
            w = ($urandom & ~32'h0070_0000) | (32'(s) << 20);
            reg_write(w);
            {eng_dat_out, eng_dat_oe, eng_clk, mac_tx_en} = 4'($urandom);
            {mac_rx_dv, mac_tx_clk, mac_rx_clk, shr_dat_i} = 4'($urandom);
            ext_lvl = 3'($urandom);
            @(negedge clk); @(negedge clk);
            check_all(w);
        end

        // constrained random
        for (int i = 0; i < 300; i++) begin
            w = $urandom;
            if (i % 4 != 0) w[22] = 1'b0;
            reg_write(w);
            {eng_dat_out, eng_dat_oe, eng_clk, mac_tx_en} = 4'($urandom);
            {mac_rx_dv, mac_tx_clk, mac_rx_clk, shr_dat_i} = 4'($urandom);
            ext_lvl = 3'($urandom);
            @(negedge clk); @(negedge clk);
            check_all(w);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule